// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block keeps the two threshold offsets that a FIFO's partial flags compare against. The low-threshold offset drives the almost-empty flag and the high-threshold offset drives the almost-full flag. When the whole-block reset is applied, the level of the offset-access pin picks the programming method. The same level also picks the default value, which is loaded into both offsets. After reset, software or a neighbouring controller reprograms the offsets. It does this either one bit per clock through a serial input or one word per clock from the write data bus, depending on the method chosen at reset.

Both offsets can also be read back, one per cycle, onto a read data bus. This works with either method. Offset access reuses the ordinary write-enable and read-enable strobes, qualified by the offset-access pin. Qualified cycles are offset traffic only and never reach the FIFO storage. A partial reset suspends all offset traffic while it is held. It keeps everything the block stores.

Top module: `flag_ofs_loader`

## Requirements
- R1: On a clock edge with `rst_all` high, both offsets become 127 and parallel programming is selected when `ofs_acc` is low. They become 1023 and serial programming is selected when `ofs_acc` is high. `rd_data` becomes 0.
- R2: `rst_all` returns the parallel word order, the readback order and the serial bit position to their starting point, which is the low-threshold offset (bit 0 for serial).
- R3: With parallel programming, each edge with `ofs_acc` and `wr_en` high stores `wr_data[OFS_W-1:0]` into the low-threshold offset, and the next such edge stores it into the high-threshold offset. The two alternate from then on. Bits of `wr_data` above OFS_W-1 are ignored.
- R4: With serial programming, each edge with `ofs_acc` and `ser_en` high writes `ser_in` into one bit. Positions 0 to OFS_W-1 are bits 0 upward of the low-threshold offset. Positions OFS_W to 2*OFS_W-1 are bits 0 upward of the high-threshold offset. Each bit takes effect at once, and after the last position the next bit goes back to position 0.
- R5: `ofs_acc` with `ser_en` has no effect under parallel programming. `ofs_acc` with `wr_en` has no effect under serial programming.
- R6: With `ofs_acc` low, `wr_en`, `ser_en` and `rd_en` change neither offset nor `rd_data`.
- R7: Each edge with `ofs_acc` and `rd_en` high places an offset on `rd_data` one cycle later, zero-extended, in the order low then high, alternating. The value shown is the one held before that edge. This works under either programming method.
- R8: While `rst_all_n`-free partial reset `rst_part` is high, all strobes are ignored. The offsets, the programming method, both orders and the serial position are kept, and traffic resumes where it stopped.
- R9: Writing one offset never changes the other.
- R10: `rst_all` takes priority over every strobe on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_all | input | 1 | Synchronous whole-block reset, active high |
| rst_part | input | 1 | Partial reset, active high; holds all offset state |
| ofs_acc | input | 1 | Offset access qualifier; also selects method and default during `rst_all` |
| ser_en | input | 1 | Serial bit strobe |
| wr_en | input | 1 | Write strobe shared with FIFO writes |
| rd_en | input | 1 | Read strobe shared with FIFO reads |
| ser_in | input | 1 | Serial offset bit |
| wr_data | input | DATA_W | Write data bus |
| low_thr | output | OFS_W | Almost-empty offset |
| high_thr | output | OFS_W | Almost-full offset |
| rd_data | output | DATA_W | Offset readback bus |

## Verification
The hardest state to reach is a serial or parallel load that is interrupted partway. Examples are a serial stream broken by a partial reset after a few bits, a parallel pair split by a partial reset or a whole-block reset, and a readback issued on the same edge as a write. The bench drives these through the normal strobes. It keeps its own model of the word order, readback order and bit position, and checks both offsets and the readback bus after every cycle. Serial loads are swept over two dozen arithmetic value pairs, bit by bit, so every bit position of both offsets is checked as it lands.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

  // True when serial position cnt falls in the high-threshold offset
  function automatic logic pos_in_high(input int cnt, input int w);
    return cnt >= w;
  endfunction

  // Bit index inside the targeted offset for serial position cnt
  function automatic int pos_bit(input int cnt, input int w);
    return (cnt >= w) ? cnt - w : cnt;
  endfunction

  // Next serial position, wrapping after both offsets are filled
  function automatic int pos_next(input int cnt, input int w);
    return (cnt == 2 * w - 1) ? 0 : cnt + 1;
  endfunction

  // Default offset chosen by the access pin level at whole-block reset
  function automatic int reset_default(input logic serial, input int par_val, input int ser_val);
    return serial ? ser_val : par_val;
  endfunction

endpackage

// File: rtl/flag_ofs_store.sv
module flag_ofs_store #(
  parameter int OFS_W   = 11,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic             clk,
  input  logic             rst_all,
  input  logic             rst_part,
  input  logic             ofs_acc,
  input  logic             ser_en,
  input  logic             wr_en,
  input  logic             ser_in,
  input  logic [OFS_W-1:0] din_lo,
  output logic [OFS_W-1:0] low_thr,
  output logic [OFS_W-1:0] high_thr
);
  import flag_ofs_pkg::*;

  localparam int CNT_W = $clog2(2 * OFS_W);
  localparam int POS_W = $clog2(OFS_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(2 * OFS_W - 1);

  logic             ser_mode;
  logic             wr_tog;
  logic [CNT_W-1:0] bit_cnt;

  // Named events for the assertions
  logic             par_wr;
  logic             ser_wr;
  logic             ser_to_high;
  logic [POS_W-1:0] ser_pos;
  logic [CNT_W-1:0] cnt_nxt;
  logic [OFS_W-1:0] dflt;

  assign par_wr      = !rst_all && !rst_part && ofs_acc && wr_en && !ser_mode;
  assign ser_wr      = !rst_all && !rst_part && ofs_acc && ser_en && ser_mode;
  assign ser_to_high = pos_in_high(int'(bit_cnt), OFS_W);
  assign ser_pos     = POS_W'(pos_bit(int'(bit_cnt), OFS_W));
  assign cnt_nxt     = CNT_W'(pos_next(int'(bit_cnt), OFS_W));
  assign dflt        = OFS_W'(reset_default(ofs_acc, DEF_PAR, DEF_SER));

  always_ff @(posedge clk) begin
    if (rst_all) begin
      ser_mode <= ofs_acc;
      low_thr  <= dflt;
      high_thr <= dflt;
      wr_tog   <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      if (par_wr) begin
        if (wr_tog) high_thr <= din_lo;
        else        low_thr  <= din_lo;
        wr_tog <= ~wr_tog;
      end
      if (ser_wr) begin
        if (ser_to_high) high_thr[ser_pos] <= ser_in;
        else             low_thr[ser_pos]  <= ser_in;
        bit_cnt <= cnt_nxt;
      end
    end
  end

  // R3
  par_low_wr_chk: assert property (@(posedge clk) disable iff (rst_all)
    (par_wr && !wr_tog) |=> (low_thr == $past(din_lo)));

  // R9
  par_low_keeps_high_chk: assert property (@(posedge clk) disable iff (rst_all)
    (par_wr && !wr_tog) |=> $stable(high_thr));

  // R5
  ser_ignores_wr_chk: assert property (@(posedge clk) disable iff (rst_all)
    (ser_mode && ofs_acc && wr_en && !ser_en) |=> ($stable(low_thr) && $stable(high_thr)));

  // R8
  part_hold_chk: assert property (@(posedge clk) disable iff (rst_all)
    rst_part |=> ($stable(low_thr) && $stable(high_thr) && $stable(ser_mode) && $stable(bit_cnt)));

  // R4
  ser_wrap_chk: assert property (@(posedge clk) disable iff (rst_all)
    (ser_wr && bit_cnt == LAST_POS) |=> (bit_cnt == '0));

  // R6
  no_acc_hold_chk: assert property (@(posedge clk) disable iff (rst_all)
    !ofs_acc |=> ($stable(low_thr) && $stable(high_thr)));

endmodule

// File: rtl/flag_ofs_readback.sv
module flag_ofs_readback #(
  parameter int OFS_W  = 11,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_all,
  input  logic              rst_part,
  input  logic              ofs_acc,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  low_thr,
  input  logic [OFS_W-1:0]  high_thr,
  output logic [DATA_W-1:0] rd_data
);

  logic             rd_tog;
  logic             rd_ev;
  logic [OFS_W-1:0] rd_pick;

  assign rd_ev   = !rst_all && !rst_part && ofs_acc && rd_en;
  assign rd_pick = rd_tog ? high_thr : low_thr;

  always_ff @(posedge clk) begin
    if (rst_all) begin
      rd_tog  <= 1'b0;
      rd_data <= '0;
    end else if (rd_ev) begin
      rd_data <= DATA_W'(rd_pick);
      rd_tog  <= ~rd_tog;
    end
  end

  // R7
  rb_low_chk: assert property (@(posedge clk) disable iff (rst_all)
    (rd_ev && !rd_tog) |=> (rd_data == DATA_W'($past(low_thr))));

  // R7
  rb_high_chk: assert property (@(posedge clk) disable iff (rst_all)
    (rd_ev && rd_tog) |=> (rd_data == DATA_W'($past(high_thr))));

  // R6
  rb_hold_chk: assert property (@(posedge clk) disable iff (rst_all)
    !ofs_acc |=> $stable(rd_data));

endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader #(
  parameter int DEPTH   = 2048,
  parameter int DATA_W  = 18,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023,
  localparam int OFS_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_all,
  input  logic              rst_part,
  input  logic              ofs_acc,
  input  logic              ser_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  low_thr,
  output logic [OFS_W-1:0]  high_thr,
  output logic [DATA_W-1:0] rd_data
);

  logic [OFS_W-1:0] din_lo;
  assign din_lo = wr_data[OFS_W-1:0];

  generate
    if (DATA_W > OFS_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:OFS_W];
    end
  endgenerate

  flag_ofs_store #(
    .OFS_W(OFS_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
  ) u_store (
    .clk(clk), .rst_all(rst_all), .rst_part(rst_part), .ofs_acc(ofs_acc),
    .ser_en(ser_en), .wr_en(wr_en), .ser_in(ser_in), .din_lo(din_lo),
    .low_thr(low_thr), .high_thr(high_thr)
  );

  flag_ofs_readback #(
    .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) u_rb (
    .clk(clk), .rst_all(rst_all), .rst_part(rst_part), .ofs_acc(ofs_acc),
    .rd_en(rd_en), .low_thr(low_thr), .high_thr(high_thr), .rd_data(rd_data)
  );

  // R10
  reset_wins_chk: assert property (@(posedge clk)
    (rst_all && ofs_acc) |=> (low_thr == OFS_W'(DEF_SER) && high_thr == OFS_W'(DEF_SER)));

  // R1
  reset_par_chk: assert property (@(posedge clk)
    (rst_all && !ofs_acc) |=> (low_thr == OFS_W'(DEF_PAR) && rd_data == '0));

endmodule

// File: tb/tb_flag_ofs_loader.sv
module tb_flag_ofs_loader;
  localparam int W  = 11;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_all, rst_part, ofs_acc, ser_en, wr_en, rd_en, ser_in;
  logic [DW-1:0] wr_data;
  logic [W-1:0]  low_thr, high_thr;
  logic [DW-1:0] rd_data;

  always #4 clk = ~clk;

  flag_ofs_loader dut (
    .clk(clk), .rst_all(rst_all), .rst_part(rst_part), .ofs_acc(ofs_acc),
    .ser_en(ser_en), .wr_en(wr_en), .rd_en(rd_en), .ser_in(ser_in),
    .wr_data(wr_data), .low_thr(low_thr), .high_thr(high_thr), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model built from the requirements
  logic [W-1:0]  m_lo, m_hi;
  logic [DW-1:0] m_rd;
  bit m_ser, m_wt, m_rt;
  int m_cnt;

  task automatic cyc(input logic a, input logic p, input logic acc, input logic se,
                     input logic we, input logic re, input logic si, input logic [DW-1:0] d);
    rst_all = a; rst_part = p; ofs_acc = acc; ser_en = se; wr_en = we; rd_en = re;
    ser_in = si; wr_data = d;
    @(posedge clk);
    if (a) begin
      m_ser = acc; m_lo = acc ? W'(1023) : W'(127); m_hi = m_lo;
      m_wt = 0; m_rt = 0; m_cnt = 0; m_rd = '0;
    end else if (!p && acc) begin
      if (re) begin
        m_rd = DW'(m_rt ? m_hi : m_lo);
        m_rt = !m_rt;
      end
      if (we && !m_ser) begin
        if (m_wt) m_hi = d[W-1:0]; else m_lo = d[W-1:0];
        m_wt = !m_wt;
      end
      if (se && m_ser) begin
        if (m_cnt < W) m_lo[m_cnt] = si; else m_hi[m_cnt - W] = si;
        m_cnt = (m_cnt + 1) % (2 * W);
      end
    end
    @(negedge clk);
  endtask

  task automatic chk(input string tag);
    checks++;
    if (low_thr !== m_lo) begin
      fails++; $display("FAIL %s low_thr actual %0d expected %0d", tag, low_thr, m_lo);
    end
    checks++;
    if (high_thr !== m_hi) begin
      fails++; $display("FAIL %s high_thr actual %0d expected %0d", tag, high_thr, m_hi);
    end
    checks++;
    if (rd_data !== m_rd) begin
      fails++; $display("FAIL %s rd_data actual %0d expected %0d", tag, rd_data, m_rd);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    rst_all = 1; rst_part = 0; ofs_acc = 0; ser_en = 0; wr_en = 0; rd_en = 0;
    ser_in = 0; wr_data = '0;
    @(negedge clk);
    // R1 parallel defaults
    cyc(1,0,0,0,0,0,0,'0); cyc(1,0,0,0,0,0,0,'0); chk("R1");
    // R6 strobes without access
    cyc(0,0,0,1,1,1,1,18'h3ffff); chk("R6");
    cyc(0,0,0,0,1,1,0,18'h00155); chk("R6");
    // R5 serial strobe under parallel method
    for (int i = 0; i < 3; i++) begin cyc(0,0,1,1,0,0,1,'0); chk("R5"); end
    // R3 / R9 parallel pairs, upper bus bits set to junk
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] a, f;
      a = W'((k * 97 + 5) % 2048);
      f = W'((k * 211 + 13) % 2048);
      cyc(0,0,1,0,1,0,0,{7'h55, a}); chk("R3");
      cyc(0,0,1,0,1,0,0,{7'h2a, f}); chk("R9");
    end
    // R7 readback in parallel method, then with a write on the same edge
    for (int i = 0; i < 4; i++) begin cyc(0,0,1,0,0,1,0,'0); chk("R7"); end
    cyc(0,0,1,0,1,1,0,18'h00321); chk("R7");
    cyc(0,0,1,0,1,1,0,18'h00654); chk("R7");
    // R8 partial reset splits a parallel pair
    cyc(0,0,1,0,1,0,0,18'h00111); chk("R8");
    cyc(0,1,1,1,1,1,1,18'h007ff); chk("R8");
    cyc(0,0,1,0,1,0,0,18'h00222); chk("R8");
    // R2 whole-block reset restarts the word and readback order
    cyc(0,0,1,0,1,1,0,18'h00333); chk("R2");
    cyc(1,0,0,0,0,0,0,'0); chk("R2");
    cyc(0,0,1,0,1,1,0,18'h00444); chk("R2");
    cyc(0,0,1,0,0,1,0,'0); chk("R2");
    // R10 reset beats all strobes; serial defaults
    cyc(1,0,1,1,1,1,1,18'h00001); chk("R10");
    cyc(0,0,1,0,0,1,0,'0); chk("R1");
    // R5 parallel write under serial method
    cyc(0,0,1,0,1,0,0,18'h00005); chk("R5");
    // R4 serial sweep, checked bit by bit
    for (int p = 0; p < 24; p++) begin
      logic [W-1:0] va, vf;
      va = W'((p * 373 + 1) % 2048);
      vf = W'((p * 1499 + 7) % 2048);
      for (int b = 0; b < 2 * W; b++) begin
        cyc(0,0,1,1,0,0, (b < W) ? va[b] : vf[b - W], '0);
        chk("R4");
      end
      checks++;
      if (low_thr !== va || high_thr !== vf) begin
        fails++;
        $display("FAIL R4 pair actual %0d/%0d expected %0d/%0d", low_thr, high_thr, va, vf);
      end
    end
    // R8 partial reset in mid serial stream
    for (int b = 0; b < 5; b++) begin cyc(0,0,1,1,0,0,1,'0); chk("R8"); end
    cyc(0,1,1,1,0,1,0,'0); chk("R8");
    for (int b = 0; b < 17; b++) begin cyc(0,0,1,1,0,0,b[0],'0); chk("R8"); end
    // R7 readback under serial method
    for (int i = 0; i < 3; i++) begin cyc(0,0,1,0,0,1,0,'0); chk("R7"); end
    finish_run();
  end
endmodule